// File: doc/BRIEF.md
# Column-Sequenced Wilkinson Conversion Controller

This block is the digital side of a multichannel Wilkinson analog-to-digital converter. A run is started with a pulse and a count of occupied analog-memory columns. Columns are converted in ascending order, each one twice: a charge conversion (flag 0), then a time conversion (flag 1). For each conversion the block raises its ramp-enable output and runs one shared counter for 2^CNT_W cycles. The counter is seen by every channel in Gray code. Each channel keeps the code that is present when its own external end-of-ramp comparator rises.

When the ramp ends, the channel results go out one per cycle on a RAM write port. Each word is tagged with the conversion kind and with that channel's gain-path bit. After the last write of the last column the block gives a one-cycle completion strobe. The ramp generators and comparators are outside the block. Defaults are 36 channels, 16 columns and 12-bit results.

The controller moves through these states:
- IDLE: waits for a start.
- IDLE → SETUP when columns are used; IDLE → FINISH when the count is zero.
- SETUP: clears the latches, samples the gain bits and zeroes the counter.
- SETUP → RAMP.
- RAMP: counts. RAMP → WRITE at the terminal count.
- WRITE: one channel per cycle. After the last channel, WRITE → SETUP for the time ramp or for the next column, and WRITE → FINISH after the last column's time ramp.
- FINISH: strobes completion. FINISH → IDLE.

Top module: `wilk_conv_seq`

## Requirements
- R1: After reset the block is idle: `ramp_start`, `ram_we` and `conv_done` are low.
- R2: A `conv_start` pulse in idle samples `used_cols`. A value above N_COL is treated as N_COL. A value of zero gives `conv_done` in the next cycle, with no ramp and no write.
- R3: Each column c from 0 to used−1 gets two ramps in turn, charge then time. `col_sel` equals c in every cycle of both ramps.
- R4: `ramp_start` stays high for exactly 2^CNT_W consecutive cycles per ramp. In ramp cycle k (first cycle k=0) the shared code is k^(k>>1).
- R5: A channel whose comparator is high in ramp cycle k and was low in the cycle before stores the code of cycle k.
- R6: Only the first such rise in a ramp is stored. Rises after it in the same ramp are ignored.
- R7: A channel with no rise by the last ramp cycle stores the code of 2^CNT_W−1 (full scale).
- R8: After a ramp, `ram_we` is high for N_CH consecutive cycles, channels 0 upward, and never while `ramp_start` is high. The address is (2·column + flag)·N_CH + channel. The word is {flag at the MSB, gain bit, CNT_W-bit code}.
- R9: The gain bit is the channel's `gain_sel` in the cycle before the ramp. Changes of `gain_sel` during the ramp have no effect.
- R10: `conv_done` is high for exactly one cycle, the one right after the final write of a run.
- R11: `conv_start` while a run is busy is ignored. The run's columns and write sequence stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Run start pulse |
| used_cols | input | COL_W+1 | Number of occupied columns |
| cmp_fire | input | N_CH | End-of-ramp comparator per channel |
| gain_sel | input | N_CH | Gain-path bit per channel |
| ramp_start | output | 1 | Ramp enable, high while counting |
| col_sel | output | COL_W | Column being converted |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | CNT_W+2 | RAM write word |
| conv_done | output | 1 | Run completion strobe |

## Verification
A wrong state or column register shows up at the ports within one cycle. It appears as a ramp at the wrong time, a `col_sel` mismatch or an unexpected write, and the per-cycle comparison catches it. A wrong counter value or a faulty channel latch is only visible in the first write after that ramp, so it is seen at most 2^CNT_W+N_CH cycles later. There the stored code, gain bit, flag or address differs from the value the bench model predicts from the comparator times it drove.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RAMP,
        ST_WRITE,
        ST_FINISH
    } wcs_state_e;
endpackage

// File: rtl/wcs_gray_cnt.sv
module wcs_gray_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] gray_o,
    output logic         term_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] bin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bin_q <= '0;
        else if (clr_i) bin_q <= '0;
        else if (en_i)  bin_q <= bin_q + 1'b1;
    end

    assign gray_o = bin_q ^ (bin_q >> 1);
    assign term_o = (bin_q == MAXV);

    AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i)) |-> ($countones(gray_o ^ $past(gray_o)) == 1)); // R4
endmodule

// File: rtl/wcs_chan_latch.sv
module wcs_chan_latch #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         arm_i,
    input  logic         term_i,
    input  logic         cmp_i,
    input  logic         gain_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] val_o,
    output logic         hit_o,
    output logic         gain_o
);
    logic cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= 1'b0;
        else        cmp_q <= cmp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_o  <= '0;
            hit_o  <= 1'b0;
            gain_o <= 1'b0;
        end else if (clr_i) begin
            val_o  <= '0;
            hit_o  <= 1'b0;
            gain_o <= gain_i;
        end else if (arm_i && !hit_o && ((cmp_i && !cmp_q) || term_i)) begin
            val_o <= code_i;
            hit_o <= 1'b1;
        end
    end

    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && $past(arm_i) && $past(hit_o)) |-> (hit_o && $stable(val_o))); // R6
endmodule

// File: rtl/wcs_ctrl.sv
module wcs_ctrl
    import wcs_pkg::*;
#(
    parameter int N_CH  = 36,
    parameter int N_COL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W:0]   used_i,
    input  logic             term_i,
    output logic             cnt_clr_o,
    output logic             cnt_en_o,
    output logic             lat_clr_o,
    output logic             arm_o,
    output logic             we_o,
    output logic             done_o,
    output logic [COL_W-1:0] col_o,
    output logic             tdc_o,
    output logic [CH_W-1:0]  ch_o
);
    localparam int COL_W = $clog2(N_COL);
    localparam int CH_W  = $clog2(N_CH);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);
    localparam logic [COL_W:0]  MAX_COLS = (COL_W+1)'(N_COL);

    wcs_state_e state_q, state_d;
    logic [COL_W:0]   ncols_q;
    logic [COL_W-1:0] col_q;
    logic             tdc_q;
    logic [CH_W-1:0]  ch_q;
    logic             last_col;

    assign last_col = ({1'b0, col_q} == (ncols_q - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = (used_i == '0) ? ST_FINISH : ST_SETUP;
            ST_SETUP:  state_d = ST_RAMP;
            ST_RAMP:   if (term_i) state_d = ST_WRITE;
            ST_WRITE:  if (ch_q == LAST_CH) state_d = (tdc_q && last_col) ? ST_FINISH : ST_SETUP;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ncols_q <= '0;
            col_q   <= '0;
            tdc_q   <= 1'b0;
            ch_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    ncols_q <= (used_i > MAX_COLS) ? MAX_COLS : used_i;
                    col_q   <= '0;
                    tdc_q   <= 1'b0;
                end
                ST_RAMP: ch_q <= '0;
                ST_WRITE: begin
                    if (ch_q == LAST_CH) begin
                        if (!tdc_q) begin
                            tdc_q <= 1'b1;
                        end else if (!last_col) begin
                            tdc_q <= 1'b0;
                            col_q <= col_q + 1'b1;
                        end
                    end else begin
                        ch_q <= ch_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cnt_clr_o = 1'b0;
        cnt_en_o  = 1'b0;
        lat_clr_o = 1'b0;
        arm_o     = 1'b0;
        we_o      = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETUP:  begin cnt_clr_o = 1'b1; lat_clr_o = 1'b1; end
            ST_RAMP:   begin cnt_en_o = 1'b1; arm_o = 1'b1; end
            ST_WRITE:  we_o = 1'b1;
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end

    assign col_o = col_q;
    assign tdc_o = tdc_q;
    assign ch_o  = ch_q;

    AST_COL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_o && $past(arm_o)) |-> $stable(col_o)); // R3
    AST_NO_WE_IN_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> !arm_o); // R8
endmodule

// File: rtl/wilk_conv_seq.sv
module wilk_conv_seq #(
    parameter int N_CH  = 36,
    parameter int N_COL = 16,
    parameter int CNT_W = 12,
    localparam int COL_W = $clog2(N_COL),
    localparam int CH_W  = $clog2(N_CH),
    localparam int AW    = $clog2(N_COL * 2 * N_CH),
    localparam int DW    = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic [COL_W:0]   used_cols,
    input  logic [N_CH-1:0]  cmp_fire,
    input  logic [N_CH-1:0]  gain_sel,
    output logic             ramp_start,
    output logic [COL_W-1:0] col_sel,
    output logic             ram_we,
    output logic [AW-1:0]    ram_addr,
    output logic [DW-1:0]    ram_wdata,
    output logic             conv_done
);
    logic             cnt_clr, cnt_en, lat_clr, arm, term, tdc;
    logic [CH_W-1:0]  ch;
    logic [CNT_W-1:0] code;
    logic [CNT_W-1:0] val_arr [N_CH];
    logic [N_CH-1:0]  hit_vec;
    logic [N_CH-1:0]  gain_vec;

    wcs_ctrl #(.N_CH(N_CH), .N_COL(N_COL)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(conv_start), .used_i(used_cols),
        .term_i(term), .cnt_clr_o(cnt_clr), .cnt_en_o(cnt_en), .lat_clr_o(lat_clr),
        .arm_o(arm), .we_o(ram_we), .done_o(conv_done), .col_o(col_sel),
        .tdc_o(tdc), .ch_o(ch)
    );

    wcs_gray_cnt #(.W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .en_i(cnt_en),
        .gray_o(code), .term_o(term)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        wcs_chan_latch #(.W(CNT_W)) i_lat (
            .clk(clk), .rst_n(rst_n), .clr_i(lat_clr), .arm_i(arm), .term_i(term),
            .cmp_i(cmp_fire[g]), .gain_i(gain_sel[g]), .code_i(code),
            .val_o(val_arr[g]), .hit_o(hit_vec[g]), .gain_o(gain_vec[g])
        );
    end

    assign ramp_start = arm;
    assign ram_addr   = AW'((int'(col_sel) * 2 + int'(tdc)) * N_CH + int'(ch));
    assign ram_wdata  = {tdc, gain_vec[ch], val_arr[ch]};

    AST_ALL_HIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (&hit_vec)); // R7
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && $past(ramp_start || ram_we)) |-> $past(ram_we)); // R10
endmodule

// File: tb/test_wilk_conv_seq.sv
module test_wilk_conv_seq;
    localparam int  NCH = 4;
    localparam int  NCOL = 4;
    localparam int  W = 5;
    localparam int  MAXK = (1 << W) - 1;
    localparam int  AW = $clog2(NCOL * 2 * NCH);
    localparam int  DW = W + 2;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 0, rst_n = 0, conv_start = 0;
    logic [$clog2(NCOL):0] used_cols = '0;
    logic [NCH-1:0] cmp_fire = '0, gain_sel = '0;
    logic ramp_start, ram_we, conv_done;
    logic [$clog2(NCOL)-1:0] col_sel;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;

    wilk_conv_seq #(.N_CH(NCH), .N_COL(NCOL), .CNT_W(W)) i_wilk_conv_seq (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit wd = 0, arm_done = 0, got_done = 0, prev_ramp = 0;
    int ramp_no = -1, k = 0;
    int fire_t [8][NCH];
    bit dbl [8][NCH];
    logic [NCH-1:0] gain_pat = '0;
    int qa[$], qd[$];

    function automatic int gray(int v); return v ^ (v >> 1); endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > 100000 && !wd) begin
            wd = 1; errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
        end
        // R10 / R2: done exactly when predicted
        chk(conv_done == arm_done, "R10 done timing", conv_done, arm_done);
        if (conv_done) got_done = 1;
        arm_done = 0;
        // R8: writes match expected queue
        if (ram_we) begin
            chk(!ramp_start, "R8 write during ramp", ramp_start, 0);
            if (qa.size() == 0) chk(0, "R8 unexpected write", ram_addr, -1);
            else begin
                int ea, ed;
                ea = qa.pop_front(); ed = qd.pop_front();
                chk(ram_addr == AW'(ea), "R8 address", ram_addr, ea);
                chk(ram_wdata == DW'(ed), "R5/R6/R7/R9 write word", ram_wdata, ed);
                if (qa.size() == 0) arm_done = 1;
            end
        end
        // R4: ramp length and counting; R3: column select
        if (ramp_start) begin
            if (!prev_ramp) begin ramp_no++; k = 0; end else k++;
            chk(int'(col_sel) == ramp_no / 2, "R3 col_sel", col_sel, ramp_no / 2);
        end else if (prev_ramp) begin
            chk(k == MAXK, "R4 ramp length", k + 1, MAXK + 1);
        end
        prev_ramp = ramp_start;
        for (int c = 0; c < NCH; c++) begin
            bit lv = 0;
            if (ramp_start && ramp_no < 8) begin
                int f;
                f = fire_t[ramp_no][c];
                if (f >= 0) lv = dbl[ramp_no][c] ? ((k >= f && k < f + 2) || k >= f + 4) : (k >= f);
            end
            cmp_fire[c] = lv;
        end
        // R9: scramble gain during ramps
        gain_sel = ramp_start ? ~gain_pat : gain_pat;
        conv_start = 0;
    endtask

    task automatic run(int used, logic [NCH-1:0] gp, int seed, bit restart);
        int n;
        n = (used > NCOL) ? NCOL : used;
        gain_pat = gp;
        ramp_no = -1;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < NCH; c++) begin
                fire_t[r][c] = (r * 7 + c * 11 + seed) % 40 - 4;
                if (fire_t[r][c] > MAXK) fire_t[r][c] = -1;
                dbl[r][c] = ((r + c + seed) % 3 == 0);
            end
        fire_t[0][0] = 0; dbl[0][0] = 0;
        fire_t[0][1] = MAXK; dbl[0][1] = 0;
        fire_t[1][2] = -1;
        for (int r = 0; r < 2 * n; r++)
            for (int c = 0; c < NCH; c++) begin
                int v;
                v = (fire_t[r][c] >= 0) ? gray(fire_t[r][c]) : gray(MAXK);
                qa.push_back(((r / 2) * 2 + r % 2) * NCH + c);
                qd.push_back(((r % 2) << (W + 1)) | (int'(gp[c]) << W) | v);
            end
        tick();
        conv_start = 1;
        used_cols = ($clog2(NCOL) + 1)'(used);
        if (n == 0) arm_done = 1;
        got_done = 0;
        for (int t = 0; !got_done && !wd; t++) begin
            tick();
            if (restart && t == 20) begin conv_start = 1; used_cols = 1; end
        end
        chk(qa.size() == 0, "R2/R11 all writes done", qa.size(), 0);
        for (int t = 0; t < 3; t++) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!ramp_start && !ram_we && !conv_done, "R1 reset state",
            {ramp_start, ram_we, conv_done}, 0);
        rst_n = 1;
        tick();
        chk(!ramp_start && !ram_we && !conv_done, "R1 idle after reset",
            {ramp_start, ram_we, conv_done}, 0);
        run(2, 4'b1010, 0, 0);          // R3 R5 R6 R7
        if (!wd) run(0, 4'b0000, 1, 0); // R2 zero columns
        if (!wd) run(NCOL + 3, 4'b0110, 5, 1); // R2 clamp, R11 restart ignored
        if (!wd) run(1, 4'b1111, 9, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule